// File: doc/BRIEF.md
# Conversion Result Holding Register with Atomic Byte Read

This block keeps the latest 10-bit conversion result and shows it to a byte-wide reader as a high byte and a low byte. The value is opaque to the block. For differential inputs it may be two's complement. A single alignment input chooses one of two layouts. In the right-aligned layout, the two top result bits sit at the bottom of the high byte. In the left-aligned layout, the two bottom result bits sit at the top of the low byte. The alignment input acts on the read data combinationally, even while a conversion is running.

Software reads the low byte first and then the high byte. To keep the two halves from belonging to different results, a low-byte read locks the held value. A result that arrives while the value is locked goes into a one-entry pending buffer. A newer arrival overwrites an older one. The high-byte read releases the lock and commits the pending value. A high-byte read with no low-byte read before it never locks.

The control is a two-state machine:
- `ST_OPEN`: results load directly.
- `ST_LOCKED`: results are diverted to the pending buffer.

It has two named transitions:
- `LOCK_ON_LOW`: `ST_OPEN` to `ST_LOCKED`. It happens on a low read without a high read in the same cycle.
- `RELEASE_ON_HIGH`: `ST_LOCKED` to `ST_OPEN`. It happens on any high read.

Top module: `rlock_result_reg`

## Requirements
- R1: With `left_adj`=0, `hi_data[1:0]` shows result bits 9:8 and `lo_data` shows result bits 7:0. `hi_data[7:2]` reads 0. For example, 0x270 reads as hi 0x02 and lo 0x70.
- R2: With `left_adj`=1, `hi_data` shows result bits 9:2 and `lo_data[7:6]` shows result bits 1:0. `lo_data[5:0]` reads 0. For example, 0x270 reads as hi 0x9C and lo 0x00.
- R3: After reset, the held value and the pending buffer are 0 and the machine is in `ST_OPEN`. Both read bytes are 0.
- R4: In `ST_OPEN`, a `res_we` pulse without a locking low read makes `res_in` visible on the read data after the next rising edge.
- R5: After a low read in `ST_OPEN` (`LOCK_ON_LOW`), results written before the next high read do not change the read data.
- R6: A high read in `ST_LOCKED` (`RELEASE_ON_HIGH`) commits a pending result. It becomes visible after that edge.
- R7: When several results arrive while locked, only the last one is committed.
- R8: A result written in the same cycle as the releasing high read wins over any older pending value and is committed at that edge.
- R9: A high read in `ST_OPEN` does not lock. A later result loads directly.
- R10: A change of `left_adj` reformats the read data in the same cycle, without a clock edge.
- R11: A result written in the same cycle as the locking low read goes to the pending buffer. The low byte read in that cycle keeps the older value.
- R12: A low read and a high read in the same cycle in `ST_OPEN` do not lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_in | input | 10 | Result word from the sequencer |
| res_we | input | 1 | Result update strobe |
| left_adj | input | 1 | 1 = left-aligned layout, 0 = right-aligned |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| lo_data | output | 8 | Low-byte read data |
| hi_data | output | 8 | High-byte read data |

## Verification
The update strobe can land in the same cycle as either read strobe:
- With the low read, it decides whether the new word is loaded directly or diverted to the pending buffer.
- With the high read, it decides whether the new word or an older pending word is committed.

Both coincidences are driven directly, with known values. Random traffic also overlaps the strobes freely. A bench model of the lock and pending buffer predicts the held word, so every read byte is judged against that prediction in both layouts.

// File: rtl/rlock_pkg.sv
package rlock_pkg;
    typedef enum logic [0:0] {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } rlock_state_t;
endpackage

// File: rtl/rlock_ctrl.sv
module rlock_ctrl
    import rlock_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         res_we,
    input  logic         rd_lo,
    input  logic         rd_hi,
    output rlock_state_t state,
    output logic         held_ld_in,
    output logic         held_ld_pend,
    output logic         pend_ld
);
    rlock_state_t state_nx;
    logic         pend_vld;
    logic         pend_clr;
    logic         lock_req;

    assign lock_req = rd_lo && !rd_hi;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend_vld <= 1'b0;
        else if (pend_clr) pend_vld <= 1'b0;
        else if (pend_ld)  pend_vld <= 1'b1;
    end

    // next state and load controls
    always_comb begin
        state_nx     = state;
        held_ld_in   = 1'b0;
        held_ld_pend = 1'b0;
        pend_ld      = 1'b0;
        pend_clr     = 1'b0;
        unique case (state)
            ST_OPEN: begin
                if (res_we) begin
                    if (lock_req) pend_ld    = 1'b1;
                    else          held_ld_in = 1'b1;
                end
                if (lock_req) state_nx = ST_LOCKED;   // LOCK_ON_LOW
            end
            ST_LOCKED: begin
                if (rd_hi) begin                      // RELEASE_ON_HIGH
                    state_nx = ST_OPEN;
                    pend_clr = 1'b1;
                    if (res_we)        held_ld_in   = 1'b1;
                    else if (pend_vld) held_ld_pend = 1'b1;
                end else if (res_we) begin
                    pend_ld = 1'b1;
                end
            end
            default: state_nx = ST_OPEN;
        endcase
    end

    AST_HI_ONLY_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && rd_hi) |=> (state == ST_OPEN));                  // R9
    AST_LOCK_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && rd_lo && !rd_hi) |=> (state == ST_LOCKED));      // R5
    AST_OPEN_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN) |-> !pend_vld);                                    // R6
endmodule

// File: rtl/rlock_store.sv
module rlock_store #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] res_in,
    input  logic             held_ld_in,
    input  logic             held_ld_pend,
    input  logic             pend_ld,
    output logic [RES_W-1:0] held
);
    logic [RES_W-1:0] pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            held <= '0;
        else if (held_ld_in)   held <= res_in;
        else if (held_ld_pend) held <= pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend <= '0;
        else if (pend_ld) pend <= res_in;
    end

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(held_ld_in && held_ld_pend));                                       // R8
    AST_COMMIT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (held_ld_pend && !held_ld_in) |=> (held == $past(pend)));             // R6
endmodule

// File: rtl/rlock_fmt.sv
module rlock_fmt #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]  held,
    input  logic              left_adj,
    output logic [BYTE_W-1:0] lo_data,
    output logic [BYTE_W-1:0] hi_data
);
    localparam int XW = RES_W - BYTE_W;
    localparam int ZW = BYTE_W - XW;

    logic [BYTE_W-1:0] hi_r, lo_r, hi_l, lo_l;

    assign hi_r = {{ZW{1'b0}}, held[RES_W-1:BYTE_W]};
    assign lo_r = held[BYTE_W-1:0];
    assign hi_l = held[RES_W-1 -: BYTE_W];
    assign lo_l = {held[XW-1:0], {ZW{1'b0}}};

    always_comb begin
        hi_data = left_adj ? hi_l : hi_r;
        lo_data = left_adj ? lo_l : lo_r;
    end
endmodule

// File: rtl/rlock_result_reg.sv
module rlock_result_reg
    import rlock_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RES_W-1:0]  res_in,
    input  logic              res_we,
    input  logic              left_adj,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] lo_data,
    output logic [BYTE_W-1:0] hi_data
);
    rlock_state_t     state;
    logic             held_ld_in, held_ld_pend, pend_ld;
    logic [RES_W-1:0] held;

    rlock_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .res_we(res_we), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .state(state), .held_ld_in(held_ld_in), .held_ld_pend(held_ld_pend),
        .pend_ld(pend_ld)
    );

    rlock_store #(.RES_W(RES_W)) u_store (
        .clk(clk), .rst_n(rst_n), .res_in(res_in), .held_ld_in(held_ld_in),
        .held_ld_pend(held_ld_pend), .pend_ld(pend_ld), .held(held)
    );

    rlock_fmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
        .held(held), .left_adj(left_adj), .lo_data(lo_data), .hi_data(hi_data)
    );

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED && !rd_hi) |=> $stable(held));                    // R5
    AST_OPEN_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && res_we && !(rd_lo && !rd_hi)) |=> (held == $past(res_in))); // R4
    AST_RELEASE_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED && rd_hi && res_we) |=> (held == $past(res_in))); // R8
    AST_COINCIDENT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && res_we && rd_lo && !rd_hi) |=> $stable(held));   // R11
endmodule

// File: tb/rlock_result_reg_tb.sv
module rlock_result_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 1234;
    localparam int N_RAND     = 2000;
    localparam int WDOG       = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] res_in = '0;
    logic       res_we = 1'b0, left_adj = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
    logic [7:0] lo_data, hi_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [9:0] m_held = '0, m_pend = '0;
    logic       m_pv = 1'b0, m_lock = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rlock_result_reg u_dut (
        .clk(clk), .rst_n(rst_n), .res_in(res_in), .res_we(res_we),
        .left_adj(left_adj), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .lo_data(lo_data), .hi_data(hi_data)
    );

    function automatic logic [15:0] fmt(input logic [9:0] v, input logic la);
        if (la) return {v[9:2], v[1:0], 6'b0};
        return {6'b0, v[9:8], v[7:0]};
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got hi/lo %h expected %h", tag, got, exp);
        end
    endtask

    // drive one cycle, check outputs for current held value, then update model at the edge
    task automatic step(input string tag, input logic we, input logic [9:0] v,
                        input logic lo, input logic hi, input logic la);
        @(negedge clk);
        res_we = we; res_in = v; rd_lo = lo; rd_hi = hi; left_adj = la;
        #1;
        chk(tag, {hi_data, lo_data}, fmt(m_held, la));
        @(posedge clk);
        if (!m_lock) begin
            if (lo && !hi) begin
                m_lock = 1'b1;
                if (we) begin m_pend = v; m_pv = 1'b1; end
            end else if (we) m_held = v;
        end else begin
            if (hi) begin
                m_lock = 1'b0;
                if (we) m_held = v;
                else if (m_pv) m_held = m_pend;
                m_pv = 1'b0;
            end else if (we) begin
                m_pend = v; m_pv = 1'b1;
            end
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WDOG) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: got %0d cycles expected < %0d", cyc, WDOG);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(SEED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 chk("R3 reset", {hi_data, lo_data}, 16'h0000);
        rst_n = 1'b1;

        step("R3 idle", 1'b1, 10'h270, 1'b0, 1'b0, 1'b0);
        step("R1 right 0x270", 1'b0, 10'h000, 1'b0, 1'b0, 1'b0);
        chk("R1 literal", {hi_data, lo_data}, 16'h0270);
        @(negedge clk); left_adj = 1'b1; #1;
        chk("R10 R2 left 0x270", {hi_data, lo_data}, 16'h9C00);
        left_adj = 1'b0; #1;
        chk("R10 back right", {hi_data, lo_data}, 16'h0270);

        step("R4 load", 1'b1, 10'h3A5, 1'b0, 1'b0, 1'b0);
        step("R4 visible", 1'b0, 10'h0, 1'b1, 1'b0, 1'b1);       // locks (R5)
        step("R5 locked", 1'b1, 10'h155, 1'b0, 1'b0, 1'b0);
        step("R7 replace", 1'b1, 10'h0AA, 1'b0, 1'b0, 1'b1);
        step("R5 still old", 1'b0, 10'h0, 1'b0, 1'b1, 1'b0);     // release
        step("R6 R7 commit newest", 1'b0, 10'h0, 1'b0, 1'b0, 1'b0);

        step("R8 lock", 1'b0, 10'h0, 1'b1, 1'b0, 1'b0);
        step("R8 pend", 1'b1, 10'h111, 1'b0, 1'b0, 1'b0);
        step("R8 release+we", 1'b1, 10'h3FF, 1'b0, 1'b1, 1'b0);
        step("R8 newest wins", 1'b0, 10'h0, 1'b0, 1'b0, 1'b1);

        step("R9 hi only", 1'b0, 10'h0, 1'b0, 1'b1, 1'b0);
        step("R9 load", 1'b1, 10'h0C3, 1'b0, 1'b0, 1'b0);
        step("R9 direct", 1'b0, 10'h0, 1'b0, 1'b0, 1'b0);

        step("R11 lock+we", 1'b1, 10'h201, 1'b1, 1'b0, 1'b0);
        step("R11 old kept", 1'b0, 10'h0, 1'b0, 1'b1, 1'b0);
        step("R11 committed", 1'b0, 10'h0, 1'b0, 1'b0, 1'b1);

        step("R12 both reads", 1'b0, 10'h0, 1'b1, 1'b1, 1'b0);
        step("R12 load", 1'b1, 10'h2DB, 1'b0, 1'b0, 1'b0);
        step("R12 not locked", 1'b0, 10'h0, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < N_RAND; i++) begin
            logic we, lo, hi, la;
            we = ($urandom % 3) == 0;
            lo = ($urandom % 4) == 0;
            hi = ($urandom % 4) == 0;
            la = $urandom % 2;
            step(la ? "R2 random" : "R1 random", we, 10'($urandom), lo, hi, la);
        end
        finish_run();
    end
endmodule